// File: doc/BRIEF.md
# PCI Target Command and Status Registers

This block keeps the Command and Status words of a PCI target's configuration header. It is used inside a network-controller-style endpoint. The Command word's enable bits gate the per-space address hits into claim outputs for I/O, memory and expansion-ROM cycles. The bus-master enable is exported as the permission the master engine must see before it starts any transaction. The parity-response enable is exported for the error-signalling logic, which lies outside this block.

The block also watches the bus as a slave for even-parity errors. It checks every address phase, and every data phase of a write that targets the device, in the cycle where both ready signals are asserted. PAR arrives one clock after the phase it covers, so AD and C/BE are folded and held for one cycle. A mismatch sets a sticky flag in the Status word. Software clears that flag by writing a one to it.

Two reset domains exist. The hard reset (`rst_ni`) clears everything. The soft reset and the stop request leave every bit of both words as it was.

Top module: `pci_cmdstat_regs`

## Requirements
- R1: Only `rst_ni` clears the Command word. Pulses on `soft_rst_i` or `stop_i` leave the Command and Status contents unchanged.
- R2: Command bits 5, 4 and 3 always read as 0, and writing ones to them has no effect. The only Command bits that can be written are 0, 1, 2 and 6, so a write of all ones reads back as 0x0047.
- R3: `io_claim_o` is 1 exactly when `io_hit_i` is 1 and Command bit 0 (I/O enable) is 1.
- R4: `mem_claim_o` is 1 exactly when `mem_hit_i` is 1 and Command bit 1 (memory enable) is 1.
- R5: `rom_claim_o` is 1 exactly when `rom_hit_i`, `rom_en_i` and Command bit 1 are all 1.
- R6: `bus_master_en_o` equals Command bit 2, and `perr_resp_en_o` equals Command bit 6.
- R7: A read with `cfg_off_i` = 1 (byte offset 04h) returns Command in bits 15:0 and Status (offset 06h) in bits 31:16. Status bit 15 (data bit 31) is the parity-error flag. Reads at any other offset, or with `cfg_rd_i` low, return 0.
- R8: An address phase (`addr_phase_i` = 1) is checked for even parity. If the XOR of AD, C/BE and the `par_i` value sampled on the following clock is 1, the parity-error flag reads 1 from the clock edge that samples `par_i` onward.
- R9: A data phase is checked only when `tgt_wr_i`, `irdy_i` and `trdy_i` are all 1 in the same cycle. If any of them is 0, a parity mismatch leaves the flag at 0.
- R10: The parity-error flag is sticky. A configuration write at offset 1 with `cfg_be_i[3]` = 1 and data bit 31 = 1 clears it. A write without byte enable 3 does not clear it, and `rst_ni` clears it.
- R11: A configuration write updates Command bits 7:0 only when `cfg_be_i[0]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset request (does not affect these registers) |
| stop_i | input | 1 | Stop request (does not affect these registers) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_off_i | input | 6 | Configuration dword index |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data |
| rom_en_i | input | 1 | ROM decode enable from the ROM base register |
| io_hit_i | input | 1 | I/O address hit |
| mem_hit_i | input | 1 | Memory-mapped register address hit |
| rom_hit_i | input | 1 | Expansion-ROM address hit |
| io_claim_o | output | 1 | Claim I/O cycle |
| mem_claim_o | output | 1 | Claim memory cycle |
| rom_claim_o | output | 1 | Claim ROM cycle |
| bus_master_en_o | output | 1 | Master transactions permitted |
| perr_resp_en_o | output | 1 | Parity-error response enable |
| ad_i | input | 32 | Address/data bus |
| cbe_i | input | 4 | Command/byte-enable bus |
| par_i | input | 1 | Parity for the previous phase |
| addr_phase_i | input | 1 | Current cycle is an address phase |
| tgt_wr_i | input | 1 | Current transaction is a write that selects this device |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| perr_o | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that `addr_phase_i`, `tgt_wr_i` and the ready signals are already decoded to active high, and that `par_i` is valid in the cycle after a checked phase. The stimulus follows this by driving each phase for one cycle, then `par_i` on the next cycle with all phase controls low. This keeps checks from overlapping. The assertions also assume configuration writes come one at a time, with no overlap with a soft reset. The bench never pulses `soft_rst_i` or `stop_i` while a write is active.

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;
  localparam int CMD_IO        = 0;
  localparam int CMD_MEM       = 1;
  localparam int CMD_BME       = 2;
  localparam int CMD_PERR_RESP = 6;
  localparam int STS_PERR      = 15;
  localparam int HALF_W        = 16;
  localparam logic [HALF_W-1:0] CMD_WR_MASK  = 16'h0047;
  localparam logic [HALF_W-1:0] STS_W1C_MASK = 16'h8000;

  typedef struct packed {
    logic perr_resp;
    logic bme;
    logic mem_en;
    logic io_en;
  } cmd_en_t;
endpackage

// File: rtl/pci_cs_cmd_reg.sv
module pci_cs_cmd_reg #(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] WR_MASK = '0,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q_q;

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[b*8 +: 8] <= '0;
      end else if (wr_i && be_i[b]) begin
        q_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & WR_MASK[b*8 +: 8];
      end
    end
  end

  assign q_o = q_q;

  // R11: byte lane left unenabled keeps its value
  p_be_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !be_i[0]) |=> $stable(q_q[7:0]));
endmodule

// File: rtl/pci_cs_sts_reg.sv
module pci_cs_sts_reg #(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] W1C_MASK = '0,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             wr_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q_q;
  logic [REG_W-1:0] clr;

  for (genvar b = 0; b < BE_W; b++) begin : g_clr
    assign clr[b*8 +: 8] = (wr_i && be_i[b]) ? (wdata_i[b*8 +: 8] & W1C_MASK[b*8 +: 8]) : '0;
  end

  // set beats clear when both land together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= ((q_q & ~clr) | set_i) & W1C_MASK;
  end

  assign q_o = q_q;

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q[REG_W-1] && !wr_i) |=> q_q[REG_W-1]);
  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[REG_W-1] |=> q_q[REG_W-1]);
endmodule

// File: rtl/pci_cs_par_chk.sv
module pci_cs_par_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             addr_phase_i,
  input  logic             tgt_wr_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  output logic             err_o
);
  logic pend_q, fold_q, take;

  assign take = addr_phase_i || (tgt_wr_i && irdy_i && trdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      fold_q <= 1'b0;
    end else begin
      pend_q <= take;
      fold_q <= ^{ad_i, cbe_i};
    end
  end

  // PAR trails its phase by one clock
  assign err_o = pend_q && (fold_q ^ par_i);

  // R9: no check without a qualified phase
  p_data_qual_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_phase_i && !(tgt_wr_i && irdy_i && trdy_i)) |=> !err_o);
endmodule

// File: rtl/pci_cs_claim.sv
module pci_cs_claim
  import pci_cs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cmd_en_t en_i,
  input  logic    rom_en_i,
  input  logic    io_hit_i,
  input  logic    mem_hit_i,
  input  logic    rom_hit_i,
  output logic    io_claim_o,
  output logic    mem_claim_o,
  output logic    rom_claim_o
);
  assign io_claim_o  = io_hit_i  && en_i.io_en;
  assign mem_claim_o = mem_hit_i && en_i.mem_en;
  assign rom_claim_o = rom_hit_i && rom_en_i && en_i.mem_en;

  p_io_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_claim_o |-> io_hit_i);
  p_mem_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_claim_o |-> mem_hit_i);
  p_rom_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_claim_o |-> (rom_en_i && rom_hit_i));
endmodule

// File: rtl/pci_cmdstat_regs.sv
module pci_cmdstat_regs
  import pci_cs_pkg::*;
#(
  parameter int AD_W      = 32,
  parameter int CBE_W     = 4,
  parameter int CFG_OFF_W = 6,
  parameter int CMD_DW    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 soft_rst_i,
  input  logic                 stop_i,
  input  logic                 cfg_wr_i,
  input  logic                 cfg_rd_i,
  input  logic [CFG_OFF_W-1:0] cfg_off_i,
  input  logic [CBE_W-1:0]     cfg_be_i,
  input  logic [AD_W-1:0]      cfg_wdata_i,
  output logic [AD_W-1:0]      cfg_rdata_o,
  input  logic                 rom_en_i,
  input  logic                 io_hit_i,
  input  logic                 mem_hit_i,
  input  logic                 rom_hit_i,
  output logic                 io_claim_o,
  output logic                 mem_claim_o,
  output logic                 rom_claim_o,
  output logic                 bus_master_en_o,
  output logic                 perr_resp_en_o,
  input  logic [AD_W-1:0]      ad_i,
  input  logic [CBE_W-1:0]     cbe_i,
  input  logic                 par_i,
  input  logic                 addr_phase_i,
  input  logic                 tgt_wr_i,
  input  logic                 irdy_i,
  input  logic                 trdy_i,
  output logic                 perr_o
);
  localparam int HBE = HALF_W / 8;

  logic              sel, cmd_wr;
  logic [HALF_W-1:0] cmd_q, sts_q, sts_set;
  logic              par_err;
  cmd_en_t           en;

  assign sel    = (cfg_off_i == CFG_OFF_W'(CMD_DW));
  assign cmd_wr = cfg_wr_i && sel;

  pci_cs_cmd_reg #(.REG_W(HALF_W), .WR_MASK(CMD_WR_MASK)) i_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cmd_wr),
    .be_i(cfg_be_i[HBE-1:0]), .wdata_i(cfg_wdata_i[HALF_W-1:0]), .q_o(cmd_q)
  );

  pci_cs_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) i_par (
    .clk_i(clk_i), .rst_ni(rst_ni), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
    .addr_phase_i(addr_phase_i), .tgt_wr_i(tgt_wr_i), .irdy_i(irdy_i),
    .trdy_i(trdy_i), .err_o(par_err)
  );

  always_comb begin
    sts_set = '0;
    sts_set[STS_PERR] = par_err;
  end

  pci_cs_sts_reg #(.REG_W(HALF_W), .W1C_MASK(STS_W1C_MASK)) i_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sts_set), .wr_i(cmd_wr),
    .be_i(cfg_be_i[CBE_W-1:HBE]), .wdata_i(cfg_wdata_i[AD_W-1:HALF_W]), .q_o(sts_q)
  );

  assign en.io_en     = cmd_q[CMD_IO];
  assign en.mem_en    = cmd_q[CMD_MEM];
  assign en.bme       = cmd_q[CMD_BME];
  assign en.perr_resp = cmd_q[CMD_PERR_RESP];

  pci_cs_claim i_claim (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .rom_en_i(rom_en_i),
    .io_hit_i(io_hit_i), .mem_hit_i(mem_hit_i), .rom_hit_i(rom_hit_i),
    .io_claim_o(io_claim_o), .mem_claim_o(mem_claim_o), .rom_claim_o(rom_claim_o)
  );

  assign bus_master_en_o = en.bme;
  assign perr_resp_en_o  = en.perr_resp;
  assign perr_o          = sts_q[STS_PERR];
  assign cfg_rdata_o     = (cfg_rd_i && sel) ? AD_W'({sts_q, cmd_q}) : '0;

  // R1: soft reset / stop never disturb the registers
  p_soft_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((soft_rst_i || stop_i) && !cmd_wr) |=> $stable(cmd_q));
  // R2: hardwired-zero command bits
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[5:3] == 3'b000);
  // R6: master permission follows the stored enable
  p_bme_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && cfg_be_i[0]) |=> (bus_master_en_o == $past(cfg_wdata_i[CMD_BME])));
endmodule

// File: tb/test_pci_cmdstat_regs.sv
module test_pci_cmdstat_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, stop = 0, cfg_wr = 0, cfg_rd = 0;
  logic [5:0] cfg_off = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic rom_en = 0, io_hit = 0, mem_hit = 0, rom_hit = 0;
  logic io_claim, mem_claim, rom_claim, bme, perr_resp, perr;
  logic [31:0] ad = '0;
  logic [3:0] cbe = '0;
  logic par = 0, addr_ph = 0, tgt_wr = 0, irdy = 0, trdy = 0;
  int n_run = 0, n_fail = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  pci_cmdstat_regs i_pci_cmdstat_regs (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .stop_i(stop),
    .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_off_i(cfg_off), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .rom_en_i(rom_en),
    .io_hit_i(io_hit), .mem_hit_i(mem_hit), .rom_hit_i(rom_hit),
    .io_claim_o(io_claim), .mem_claim_o(mem_claim), .rom_claim_o(rom_claim),
    .bus_master_en_o(bme), .perr_resp_en_o(perr_resp), .ad_i(ad), .cbe_i(cbe),
    .par_i(par), .addr_phase_i(addr_ph), .tgt_wr_i(tgt_wr), .irdy_i(irdy),
    .trdy_i(trdy), .perr_o(perr)
  );

  // {io,mem,bme, rom_en, io_hit,mem_hit,rom_hit, exp_io,exp_mem,exp_rom,exp_bme}
  localparam logic [10:0] VEC [8] = '{
    11'b000_1_111_0000,
    11'b100_1_111_1000,
    11'b010_0_111_0100,
    11'b010_1_011_0110,
    11'b001_1_111_0001,
    11'b111_1_000_0001,
    11'b110_1_101_1010,
    11'b111_0_001_0001
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] off, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_off = off; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(logic [5:0] off, output logic [31:0] d);
    cfg_off = off; cfg_rd = 1'b1;
    #1 d = cfg_rdata;
    cfg_rd = 1'b0;
  endtask

  // one phase, then PAR on the next clock; good=1 gives correct parity
  task automatic phase(logic a, logic w, logic i, logic t, logic [31:0] adv,
                       logic [3:0] cb, logic good);
    @(negedge clk);
    addr_ph = a; tgt_wr = w; irdy = i; trdy = t; ad = adv; cbe = cb;
    @(negedge clk);
    par = good ? ^{adv, cb} : ~(^{adv, cb});
    addr_ph = 0; tgt_wr = 0; irdy = 0; trdy = 0; ad = '0; cbe = '0;
    @(negedge clk);
    par = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_read(6'd1, rd); check("R7 reset read", rd, 32'h0);

    // vector table: claim gating and master enable
    foreach (VEC[k]) begin
      cfg_write(6'd1, 4'b0001, {29'b0, VEC[k][8], VEC[k][9], VEC[k][10]});
      rom_en = VEC[k][7]; io_hit = VEC[k][6]; mem_hit = VEC[k][5]; rom_hit = VEC[k][4];
      #1;
      check("R3 io claim", {31'b0, io_claim}, {31'b0, VEC[k][3]});
      check("R4 mem claim", {31'b0, mem_claim}, {31'b0, VEC[k][2]});
      check("R5 rom claim", {31'b0, rom_claim}, {31'b0, VEC[k][1]});
      check("R6 bus master", {31'b0, bme}, {31'b0, VEC[k][0]});
    end
    io_hit = 0; mem_hit = 0; rom_hit = 0; rom_en = 0;

    // R2 writable mask
    cfg_write(6'd1, 4'b1111, 32'hFFFF_FFFF);
    cfg_read(6'd1, rd); check("R2 mask", rd, 32'h0000_0047);
    check("R6 perr resp", {31'b0, perr_resp}, 32'h1);
    cfg_read(6'd2, rd); check("R7 other offset", rd, 32'h0);
    cfg_write(6'd1, 4'b0001, 32'h0000_0038);
    cfg_read(6'd1, rd); check("R2 rsvd write", rd, 32'h0);

    // R11 byte enable
    cfg_write(6'd1, 4'b0001, 32'h0000_0007);
    cfg_write(6'd1, 4'b1110, 32'h0000_0000);
    cfg_read(6'd1, rd); check("R11 be0 off", rd, 32'h0000_0007);

    // R1 soft reset and stop
    @(negedge clk); soft_rst = 1; stop = 1;
    @(negedge clk); soft_rst = 0; stop = 0;
    cfg_read(6'd1, rd); check("R1 soft/stop", rd, 32'h0000_0007);

    // R8 address phase parity
    phase(1, 0, 0, 0, 32'hA5A5_1234, 4'h6, 1);
    check("R8 good addr", {31'b0, perr}, 32'h0);
    phase(1, 0, 0, 0, 32'hA5A5_1234, 4'h6, 0);
    cfg_read(6'd1, rd); check("R8 bad addr", rd, 32'h8000_0007);

    // R10 clear rules
    cfg_write(6'd1, 4'b0100, 32'hFFFF_0000);
    check("R10 no be3", {31'b0, perr}, 32'h1);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    check("R1 soft keeps perr", {31'b0, perr}, 32'h1);
    cfg_write(6'd1, 4'b1000, 32'h8000_0000);
    check("R10 w1c", {31'b0, perr}, 32'h0);

    // R9 data phase qualification
    phase(0, 1, 1, 0, 32'h0F0F_0001, 4'h1, 0);
    check("R9 no trdy", {31'b0, perr}, 32'h0);
    phase(0, 0, 1, 1, 32'h0F0F_0001, 4'h1, 0);
    check("R9 not target", {31'b0, perr}, 32'h0);
    phase(0, 1, 1, 1, 32'h0F0F_0001, 4'h1, 1);
    check("R9 good data", {31'b0, perr}, 32'h0);
    phase(0, 1, 1, 1, 32'h0F0F_0001, 4'h1, 0);
    check("R9 bad data", {31'b0, perr}, 32'h1);

    // R1/R10 hard reset clears all
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    cfg_read(6'd1, rd); check("R1 hard reset", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule